// File: doc/BRIEF.md
# Self-Reloading Countdown Timer with Sticky Interrupt

The block is a memory-mapped down-counter of `CNT_W` bits, either 16 or 32. Software reaches it through a plain register port that carries a valid strobe, a write flag, a byte address and write data. Reads return their data one clock after the request. Four word registers sit in the window: load, live count, control and interrupt clear. One control bit picks the tick source. Each counting step is an enable pulse from either a fast prescaled tick input or a slow one.

Counting is governed by a two-state machine. ST_STOP holds the count. ST_COUNT decrements it once per selected tick. A control write with the run bit set takes the transition ST_STOP→ST_COUNT (start), or stays in ST_COUNT. A control write with the run bit clear takes ST_COUNT→ST_STOP (halt), or stays in ST_STOP. No other event changes the state.

An underflow is a selected tick that arrives in ST_COUNT while the count is zero. In periodic mode the counter then reloads from the load register. In free-running mode it wraps to all ones. Either way a sticky interrupt is set, and it stays set until software writes any value to the clear register.

Top module: `cdt_timer`

## Requirements
- R1: After reset the count, load, control and read-data registers are zero, the machine is in ST_STOP and `irq_o` is low.
- R2: A write to offset 0x00 stores the value as the load value and copies it into the count. The load value reads back at 0x00.
- R3: Control sits at offset 0x08. Bit 7 = run, bit 6 = periodic, bit 3 = fast tick select. A read returns exactly those three bits, and all other bits read 0. Writing 0 stops counting and the count holds.
- R4: In ST_COUNT the count drops by one on each selected tick. `tick_fast_i` is selected when bit 3 = 1 and `tick_slow_i` when bit 3 = 0. Pulses on the unselected input have no effect.
- R5: In periodic mode an underflow reloads the count from the load register and sets `irq_o`.
- R6: In free-running mode (bit 6 = 0) an underflow wraps the count to all ones and sets `irq_o`.
- R7: `irq_o` stays high until a write of any data to offset 0x0C. It is low in the cycle after that write.
- R8: When an underflow and a clear write fall in the same cycle, `irq_o` stays high.
- R9: Offset 0x04 returns the live count. Writes to 0x04 are ignored.
- R10: Offsets other than 0x00, 0x04, 0x08 and 0x0C read zero, and writes to them are ignored. Offset 0x0C also reads zero.
- R11: `rd_data_o` is loaded on the clock edge that samples a read request. It holds its value while no read request is present.
- R12: A load write in the same cycle as a selected tick wins. The count takes the written value, and no underflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_fast_i | input | 1 | Fast prescaled count-enable pulse |
| tick_slow_i | input | 1 | Slow prescaled count-enable pulse |
| req_valid_i | input | 1 | Register request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte offset within the window |
| req_wdata_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, valid the cycle after a read |
| irq_o | output | 1 | Sticky underflow interrupt |

## Verification
The assertions check the following on every cycle:
- a load write copies the value into the count;
- the count is frozen in ST_STOP;
- an underflow reloads the count (periodic) or wraps it to all ones (free-running);
- an underflow sets the interrupt;
- the interrupt stays high until a clear write.

Only the bench's scenarios can show the rest:
- register decoding and read-back of the control bits;
- the choice between the two tick inputs;
- the ignored writes to the value register and to unused offsets;
- the collision of a clear write with an underflow;
- the priority of a load write over a tick;
- the one-cycle read latency.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int OFF_LOAD  = 'h00;
    localparam int OFF_VALUE = 'h04;
    localparam int OFF_CTRL  = 'h08;
    localparam int OFF_CLEAR = 'h0C;

    localparam int CB_RUN      = 7;
    localparam int CB_PERIODIC = 6;
    localparam int CB_FAST     = 3;

    typedef enum logic {
        ST_STOP  = 1'b0,
        ST_COUNT = 1'b1
    } cdt_state_e;
endpackage

// File: rtl/cdt_tick_sel.sv
module cdt_tick_sel (
    input  logic fast_sel_i,
    input  logic tick_fast_i,
    input  logic tick_slow_i,
    output logic tick_o
);
    always_comb begin
        tick_o = fast_sel_i ? tick_fast_i : tick_slow_i;
    end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              running_i,
    output logic              load_wr_o,
    output logic [CNT_W-1:0]  load_val_o,
    output logic [CNT_W-1:0]  load_q_o,
    output logic              ctrl_wr_o,
    output logic              ctrl_run_o,
    output logic              periodic_o,
    output logic              fast_sel_o,
    output logic              clr_wr_o,
    output logic [DATA_W-1:0] rd_data_o
);
    logic              wr_en;
    logic              rd_en;
    logic [CNT_W-1:0]  load_q;
    logic              periodic_q;
    logic              fast_q;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] ctrl_view;

    assign wr_en      = req_valid_i && req_write_i;
    assign rd_en      = req_valid_i && !req_write_i;
    assign load_wr_o  = wr_en && (req_addr_i == ADDR_W'(OFF_LOAD));
    assign ctrl_wr_o  = wr_en && (req_addr_i == ADDR_W'(OFF_CTRL));
    assign clr_wr_o   = wr_en && (req_addr_i == ADDR_W'(OFF_CLEAR));
    assign load_val_o = req_wdata_i[CNT_W-1:0];
    assign ctrl_run_o = req_wdata_i[CB_RUN];
    assign load_q_o   = load_q;
    assign periodic_o = periodic_q;
    assign fast_sel_o = fast_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q     <= '0;
            periodic_q <= 1'b0;
            fast_q     <= 1'b0;
        end else begin
            if (load_wr_o) begin
                load_q <= req_wdata_i[CNT_W-1:0];
            end
            if (ctrl_wr_o) begin
                periodic_q <= req_wdata_i[CB_PERIODIC];
                fast_q     <= req_wdata_i[CB_FAST];
            end
        end
    end

    always_comb begin
        ctrl_view              = '0;
        ctrl_view[CB_RUN]      = running_i;
        ctrl_view[CB_PERIODIC] = periodic_q;
        ctrl_view[CB_FAST]     = fast_q;
        unique case (1'b1)
            req_addr_i == ADDR_W'(OFF_LOAD):  rd_mux = DATA_W'(load_q);
            req_addr_i == ADDR_W'(OFF_VALUE): rd_mux = DATA_W'(count_i);
            req_addr_i == ADDR_W'(OFF_CTRL):  rd_mux = ctrl_view;
            default:                          rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en) begin
            rd_data_o <= rd_mux;
        end
    end

    // R11
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data_o));
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter
    import cdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_wr_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_run_i,
    input  logic             periodic_i,
    input  logic             tick_i,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             underflow_o
);
    cdt_state_e       state_q;
    cdt_state_e       state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_d;

    // state transitions: start / halt on control writes only
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP:  if (ctrl_wr_i && ctrl_run_i)  state_d = ST_COUNT;
            ST_COUNT: if (ctrl_wr_i && !ctrl_run_i) state_d = ST_STOP;
            default:  state_d = ST_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // outputs and count datapath
    always_comb begin
        underflow_o = 1'b0;
        count_d     = count_q;
        if (load_wr_i) begin
            count_d = load_val_i;
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (tick_i) begin
                        if (count_q == '0) begin
                            underflow_o = 1'b1;
                            count_d     = periodic_i ? reload_val_i : '1;
                        end else begin
                            count_d = count_q - 1'b1;
                        end
                    end
                end
                default: count_d = count_q;
            endcase
        end
    end

    assign count_o   = count_q;
    assign running_o = (state_q == ST_COUNT);

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr_i |=> count_q == $past(load_val_i));

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !load_wr_i) |=> $stable(count_q));

    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && periodic_i) |=> count_q == $past(reload_val_i));

    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_o && !periodic_i) |=> count_q == {CNT_W{1'b1}});
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow_i,
    input  logic clr_wr_i,
    output logic irq_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= underflow_i || (irq_o && !clr_wr_i);
        end
    end

    // R5
    irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_i |=> irq_o);

    // R7
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !clr_wr_i) |=> irq_o);

    // R7
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr_i && !underflow_i) |=> !irq_o);
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
    import cdt_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_fast_i,
    input  logic              tick_slow_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    logic             load_wr;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] load_q;
    logic             ctrl_wr;
    logic             ctrl_run;
    logic             periodic;
    logic             fast_sel;
    logic             clr_wr;
    logic             tick;
    logic [CNT_W-1:0] count;
    logic             running;
    logic             underflow;

    initial begin
        assert (CNT_W == 16 || CNT_W == 32) else $error("CNT_W must be 16 or 32");
        assert (DATA_W >= CNT_W && DATA_W >= 8) else $error("DATA_W too narrow");
    end

    cdt_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_write_i (req_write_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .count_i     (count),
        .running_i   (running),
        .load_wr_o   (load_wr),
        .load_val_o  (load_val),
        .load_q_o    (load_q),
        .ctrl_wr_o   (ctrl_wr),
        .ctrl_run_o  (ctrl_run),
        .periodic_o  (periodic),
        .fast_sel_o  (fast_sel),
        .clr_wr_o    (clr_wr),
        .rd_data_o   (rd_data_o)
    );

    cdt_tick_sel tick_i (
        .fast_sel_i  (fast_sel),
        .tick_fast_i (tick_fast_i),
        .tick_slow_i (tick_slow_i),
        .tick_o      (tick)
    );

    cdt_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_wr_i    (load_wr),
        .load_val_i   (load_val),
        .reload_val_i (load_q),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_run_i   (ctrl_run),
        .periodic_i   (periodic),
        .tick_i       (tick),
        .count_o      (count),
        .running_o    (running),
        .underflow_o  (underflow)
    );

    cdt_irq irq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .underflow_i (underflow),
        .clr_wr_i    (clr_wr),
        .irq_o       (irq_o)
    );
endmodule

// File: tb/cdt_timer_tb_top.sv
module cdt_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cdt_timer dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_fast_i (tick_fast),
        .tick_slow_i (tick_slow),
        .req_valid_i (req_valid),
        .req_write_i (req_write),
        .req_addr_i  (req_addr),
        .req_wdata_i (req_wdata),
        .rd_data_o   (rd_data),
        .irq_o       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    task automatic pulse(input bit fast, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fast) tick_fast = 1'b1; else tick_slow = 1'b1;
            @(negedge clk);
            tick_fast = 1'b0; tick_slow = 1'b0;
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 rd_data after reset", rd_data, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        rd(8'h00, v); chk("R1 load after reset", v, 32'h0);
        rd(8'h04, v); chk("R1 count after reset", v, 32'h0);
        rd(8'h08, v); chk("R1 ctrl after reset", v, 32'h0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(8'h00, 32'd5);
        rd(8'h00, v); chk("R2 load readback", v, 32'd5);
        rd(8'h04, v); chk("R2 count copied from load", v, 32'd5);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R3 ctrl readback bits 7,6,3", v, 32'h0000_00C8);
        wr(8'h08, 32'h0);
        rd(8'h08, v); chk("R3 ctrl cleared", v, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(8'h00, 32'd3);
        wr(8'h08, 32'hC8);
        pulse(1'b1, 2);
        rd(8'h04, v); chk("R4 fast ticks decrement", v, 32'd1);
        pulse(1'b0, 2);
        rd(8'h04, v); chk("R4 slow ignored when fast selected", v, 32'd1);
        wr(8'h08, 32'hC0);
        pulse(1'b1, 2);
        rd(8'h04, v); chk("R4 fast ignored when slow selected", v, 32'd1);
        pulse(1'b0, 1);
        rd(8'h04, v); chk("R4 slow tick decrements", v, 32'd0);
        chk("R5 no irq before underflow", {31'b0, irq}, 32'h0);
        pulse(1'b0, 1);
        rd(8'h04, v); chk("R5 periodic reload", v, 32'd3);
        chk("R5 irq on underflow", {31'b0, irq}, 32'h1);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        pulse(1'b1, 2);
        pulse(1'b0, 1);
        chk("R7 irq stays set", {31'b0, irq}, 32'h1);
        rd(8'h04, v); chk("R4 count after sticky ticks", v, 32'd2);
        wr(8'h0C, 32'h0000_DEAD);
        chk("R7 irq cleared by any write", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_stop();
        logic [31:0] v;
        wr(8'h08, 32'h0);
        pulse(1'b0, 3);
        pulse(1'b1, 3);
        rd(8'h04, v); chk("R3 count holds when stopped", v, 32'd2);
    endtask

    task automatic t_freerun();
        logic [31:0] v;
        wr(8'h00, 32'd1);
        wr(8'h08, 32'h88);
        pulse(1'b1, 1);
        chk("R6 no irq at zero", {31'b0, irq}, 32'h0);
        pulse(1'b1, 1);
        rd(8'h04, v); chk("R6 wrap to all ones", v, 32'hFFFF_FFFF);
        chk("R6 irq on wrap", {31'b0, irq}, 32'h1);
        pulse(1'b1, 1);
        rd(8'h04, v); chk("R6 counts on after wrap", v, 32'hFFFF_FFFE);
        wr(8'h0C, 32'h0);
    endtask

    task automatic t_collide();
        wr(8'h00, 32'd0);
        chk("R8 irq low before collision", {31'b0, irq}, 32'h0);
        @(negedge clk);
        tick_fast = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h0C; req_wdata = 32'h1;
        @(negedge clk);
        tick_fast = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        chk("R8 underflow beats clear", {31'b0, irq}, 32'h1);
        wr(8'h0C, 32'h1);
        chk("R7 clear after collision", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_value_ro();
        logic [31:0] v;
        wr(8'h04, 32'h0000_1234);
        rd(8'h04, v); chk("R9 value write ignored", v, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R9 load untouched by value write", v, 32'h0);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(8'h10, 32'hAAAA_AAAA);
        wr(8'h44, 32'h5555_5555);
        rd(8'h10, v); chk("R10 unused offset reads zero", v, 32'h0);
        rd(8'h0C, v); chk("R10 clear offset reads zero", v, 32'h0);
        rd(8'h08, v); chk("R10 ctrl unchanged", v, 32'h88);
        rd(8'h00, v); chk("R10 load unchanged", v, 32'h0);
        rd(8'h04, v); chk("R10 count unchanged", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(8'h00, 32'd0);
        @(negedge clk);
        tick_fast = 1'b1; req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 32'd9;
        @(negedge clk);
        tick_fast = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        rd(8'h04, v); chk("R12 load wins over tick", v, 32'd9);
        chk("R12 no underflow irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_rdhold();
        logic [31:0] v;
        rd(8'h00, v); chk("R11 read data after one cycle", v, 32'd9);
        pulse(1'b1, 2);
        chk("R11 rd_data holds without request", rd_data, 32'd9);
        rd(8'h04, v); chk("R11 live count read", v, 32'd7);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_load();
        t_ctrl();
        t_count();
        t_sticky();
        t_stop();
        t_freerun();
        t_collide();
        t_value_ro();
        t_unimpl();
        t_prio();
        t_rdhold();
        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule